// File: doc/BRIEF.md
# Status Register Write Protection Unit

This block keeps the protection status byte of a serial memory slave and decides, cycle by cycle, whether a memory byte write or a status write may go ahead. A command decoder in front of it turns serial traffic into single-cycle strobes. These strobes mark the start of a command (chip select fall), setting or clearing the write-enable latch, a status write with its data byte, a committed memory byte with its address, and the end of a command. The block answers with a status byte for reads and two grant signals. Serial shifting and the memory array live elsewhere.

The protection scheme has three layers. The first is a write-enable latch, which software sets before each write operation and which clears itself once that operation ends. The second is a pair of block-select bits that lock the upper quarter, the upper half or the whole array. The third is an active-low protect pin. That pin can lock the status byte, but only when a pin-enable bit in the status byte is set. The pin is captured once per command, at chip select fall.

Two resets exist. A power-on reset clears every bit. A soft reset clears only the latch, so the pin-enable and block-select bits act as if they were nonvolatile.

Top module: `wp_guard`

## Requirements
- R1: The status byte is laid out as bit7 pin-enable, bit6 constant 1, bits 5:4 constant 0, bits 3:2 block-select, bit1 write-enable latch, bit0 constant 0. The constant bits never change, whatever data a status write carries.
- R2: After power-on reset the status byte reads 8'h40.
- R3: A set-latch strobe makes bit1 read 1 from the next cycle. A clear-latch strobe makes it read 0 from the next cycle.
- R4: A granted status write does not change bit1. A data bit1 of 0 leaves the latch set until the command ends.
- R5: When a command ends in which a status or memory write strobe occurred, the latch reads 0 from the next cycle. Within the command the latch stays set, so every byte of a burst is granted.
- R6: For a 17-bit address, block-select 00 locks nothing, 01 locks 18000h to 1FFFFh, 10 locks 10000h to 1FFFFh, and 11 locks every address.
- R7: The memory grant is high exactly when the latch is set and the address is not locked. The protect pin has no effect on it.
- R8: The status grant is high exactly when the latch is set and not (pin-enable = 1 and the pin captured at the last chip select fall = 0). A pin change after that fall has no effect within the command.
- R9: A status write that is denied leaves bits 7 and 3:2 unchanged, and the latch still clears at command end.
- R10: A soft reset clears the latch and keeps pin-enable and block-select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears all state |
| rst_n | input | 1 | Soft reset, active low, synchronous; clears the latch only |
| cs_fall | input | 1 | Command start strobe; captures the protect pin |
| set_wel | input | 1 | Set-latch command strobe |
| clr_wel | input | 1 | Clear-latch command strobe |
| sr_wr | input | 1 | Status write strobe |
| sr_data | input | 8 | Status write data byte |
| mem_wr | input | 1 | Memory byte write strobe |
| mem_addr | input | 17 | Address of the pending memory byte |
| cmd_end | input | 1 | Command end strobe (chip select rise) |
| wp_n | input | 1 | Protect pin, active low |
| status | output | 8 | Status byte for reads |
| mem_wr_ok | output | 1 | Memory write grant for mem_addr |
| sr_wr_ok | output | 1 | Status write grant |

## Verification
The bench probes the edges of each block-select range: the last address below each boundary and the first address at it. A wrong decode shows up there as a granted write into locked space or a refused write to free space. It runs a multi-byte burst. A design that cleared the latch per byte would refuse the second byte, and one that never cleared it would leave writes open after the command. It toggles the protect pin in the middle of a command. A design that follows the live pin would grant or refuse a status write on the wrong pin level. It also sends denied status writes and soft resets. A design that lets a denied write through, or drops the block-select bits on soft reset, would show a changed status byte.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

    typedef struct packed {
        logic       wel;   // write-enable latch
        logic       pen;   // protect pin enable (kept across soft reset)
        logic [1:0] bp;    // block select (kept across soft reset)
        logic       pin;   // protect pin captured at command start
        logic       seen;  // a write strobe occurred in this command
    } wpg_state_t;

    localparam wpg_state_t WPG_POR = '{wel: 1'b0, pen: 1'b0, bp: 2'b00, pin: 1'b1, seen: 1'b0};

    function automatic logic [7:0] wpg_pack(input wpg_state_t s);
        return {s.pen, 1'b1, 2'b00, s.bp, s.wel, 1'b0};
    endfunction

endpackage

// File: rtl/wpg_range.sv
module wpg_range #(
    parameter int ADDR_W = 17
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);
    localparam int TOP = ADDR_W - 1;

    always_comb begin
        unique case (bp)
            2'b00:   locked = 1'b0;
            2'b01:   locked = addr[TOP] & addr[TOP-1];
            2'b10:   locked = addr[TOP];
            default: locked = 1'b1;
        endcase
    end
endmodule

// File: rtl/wpg_state.sv
module wpg_state
    import wpg_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_n,
    input  logic       cs_fall,
    input  logic       set_wel,
    input  logic       clr_wel,
    input  logic       sr_wr,
    input  logic [7:0] sr_data,
    input  logic       mem_wr,
    input  logic       cmd_end,
    input  logic       wp_n,
    output logic [7:0] status,
    output logic [1:0] bp,
    output logic       wel,
    output logic       sr_ok
);
    wpg_state_t st_q, st_d;
    logic       wr_any;

    assign wr_any = sr_wr | mem_wr;
    assign sr_ok  = st_q.wel & ~(st_q.pen & ~st_q.pin);

    always_comb begin
        st_d = st_q;
        if (!por_n) begin
            st_d = WPG_POR;
        end else if (!rst_n) begin
            st_d.wel  = 1'b0;
            st_d.pin  = 1'b1;
            st_d.seen = 1'b0;
        end else begin
            if (cs_fall) st_d.pin = wp_n;
            if (cmd_end)      st_d.seen = 1'b0;
            else if (cs_fall) st_d.seen = wr_any;
            else              st_d.seen = st_q.seen | wr_any;
            if (cmd_end && (st_q.seen || wr_any)) st_d.wel = 1'b0;
            else if (set_wel)                     st_d.wel = 1'b1;
            else if (clr_wel)                     st_d.wel = 1'b0;
            if (sr_wr && sr_ok) begin
                st_d.pen = sr_data[7];
                st_d.bp  = sr_data[3:2];
            end
        end
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign status = wpg_pack(st_q);
    assign bp     = st_q.bp;
    assign wel    = st_q.wel;

    assert_wel_set_R3: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (set_wel && !cmd_end) |=> status[1]);
    assert_wel_end_R5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (cmd_end && mem_wr) |=> !status[1]);
    assert_denied_hold_R9: assert property (@(posedge clk) disable iff (!por_n)
        !(sr_wr && sr_ok) |=> ($stable(status[7]) && $stable(status[3:2])));
    assert_pin_hold_R8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        !cs_fall |=> $stable(st_q.pin));
    assert_soft_keep_R10: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> (!status[1] && $stable(status[7:2])));
endmodule

// File: rtl/wp_guard.sv
module wp_guard #(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              cs_fall,
    input  logic              set_wel,
    input  logic              clr_wel,
    input  logic              sr_wr,
    input  logic [7:0]        sr_data,
    input  logic              mem_wr,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              cmd_end,
    input  logic              wp_n,
    output logic [7:0]        status,
    output logic              mem_wr_ok,
    output logic              sr_wr_ok
);
    logic [1:0] bp;
    logic       wel;
    logic       locked;

    wpg_state u_state (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .cs_fall(cs_fall),
        .set_wel(set_wel), .clr_wel(clr_wel), .sr_wr(sr_wr), .sr_data(sr_data),
        .mem_wr(mem_wr), .cmd_end(cmd_end), .wp_n(wp_n),
        .status(status), .bp(bp), .wel(wel), .sr_ok(sr_wr_ok)
    );

    wpg_range #(.ADDR_W(ADDR_W)) u_range (
        .bp(bp), .addr(mem_addr), .locked(locked)
    );

    assign mem_wr_ok = wel & ~locked;

    assert_all_locked_R6: assert property (@(posedge clk) disable iff (!por_n)
        (status[3:2] == 2'b11) |-> !mem_wr_ok);
    assert_fixed_bits_R1: assert property (@(posedge clk) disable iff (!por_n)
        sr_wr |=> (status[6] && status[5:4] == 2'b00 && !status[0]));
endmodule

// File: tb/wp_guard_test.sv
module wp_guard_test;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        por_n = 1'b0, rst_n = 1'b1, cs_fall = 1'b0, set_wel = 1'b0, clr_wel = 1'b0;
    logic        sr_wr = 1'b0, mem_wr = 1'b0, cmd_end = 1'b0, wp_n = 1'b1;
    logic [7:0]  sr_data = 8'h00;
    logic [16:0] mem_addr = '0;
    logic [7:0]  status;
    logic        mem_wr_ok, sr_wr_ok;

    wp_guard uut (.*);

    int  vectors = 0, miscompares = 0, cycles = 0;
    bit  m_valid = 0, m_wel, m_pen, m_pin, m_seen;
    bit [1:0] m_bp;

    function automatic bit locked_at(input bit [1:0] b, input logic [16:0] a);
        case (b)
            2'd0: return 0;
            2'd1: return a >= 17'h18000;
            2'd2: return a >= 17'h10000;
            default: return 1;
        endcase
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout, expected completion");
            summary();
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        bit esr, emem;
        if (!m_valid) return;
        esr  = m_wel && !(m_pen && !m_pin);
        emem = m_wel && !locked_at(m_bp, mem_addr);
        chk({tag, " status"}, status, {m_pen, 1'b1, 2'b00, m_bp, m_wel, 1'b0});
        chk({tag, " mem grant"}, {7'd0, mem_wr_ok}, {7'd0, emem});
        chk({tag, " status grant"}, {7'd0, sr_wr_ok}, {7'd0, esr});
    endtask

    task automatic model_update();
        bit wr, grant;
        wr = sr_wr | mem_wr;
        grant = m_wel && !(m_pen && !m_pin);
        if (!por_n) begin
            m_wel = 0; m_pen = 0; m_bp = 0; m_pin = 1; m_seen = 0; m_valid = 1;
        end else if (!rst_n) begin
            m_wel = 0; m_pin = 1; m_seen = 0;
        end else begin
            if (cmd_end && (m_seen || wr)) m_wel = 0;
            else if (set_wel) m_wel = 1;
            else if (clr_wel) m_wel = 0;
            if (sr_wr && grant) begin m_pen = sr_data[7]; m_bp = sr_data[3:2]; end
            if (cmd_end) m_seen = 0;
            else if (cs_fall) m_seen = wr;
            else m_seen = m_seen | wr;
            if (cs_fall) m_pin = wp_n;
        end
    endtask

    task automatic tick(input string tag);
        #1 compare(tag);
        @(posedge clk);
        model_update();
        @(negedge clk);
        cs_fall = 0; set_wel = 0; clr_wel = 0; sr_wr = 0; mem_wr = 0; cmd_end = 0;
    endtask

    task automatic cmd_set(input string tag);
        cs_fall = 1; tick(tag); set_wel = 1; tick(tag); cmd_end = 1; tick(tag);
    endtask

    task automatic cmd_clr(input string tag);
        cs_fall = 1; tick(tag); clr_wel = 1; tick(tag); cmd_end = 1; tick(tag);
    endtask

    task automatic cmd_sr(input string tag, input logic [7:0] d, input logic pin);
        wp_n = pin; cs_fall = 1; tick(tag);
        sr_wr = 1; sr_data = d; tick(tag);
        cmd_end = 1; tick(tag);
    endtask

    initial begin
        @(negedge clk);
        tick("R2"); tick("R2");
        por_n = 1;
        #1 chk("R2 reset status", status, 8'h40);
        tick("R2");

        // Write attempt with latch clear
        cs_fall = 1; tick("R7"); mem_wr = 1; mem_addr = 17'h00000;
        #1 chk("R7 no latch", {7'd0, mem_wr_ok}, 8'd0);
        tick("R7"); cmd_end = 1; tick("R7");

        cmd_set("R3");
        chk("R3 latch set", status, 8'h42);
        cmd_clr("R3");
        chk("R3 latch clear", status, 8'h40);

        // Constant bits and latch bit ignored by status write
        cmd_set("R4");
        wp_n = 1; cs_fall = 1; tick("R4");
        sr_wr = 1; sr_data = 8'h71; tick("R1");
        chk("R4 latch kept in command", status, 8'h42);
        cmd_end = 1; tick("R5");
        chk("R1 constant bits", status, 8'h40);

        // Range sweep per block select
        for (int b = 0; b < 4; b++) begin
            cmd_set("R6");
            cmd_sr("R6", {4'b0, 2'(b), 2'b00}, 1'b1);
            cmd_set("R6");
            cs_fall = 1; tick("R6");
            foreach (uut.status[i]) begin end
            for (int k = 0; k < 6; k++) begin
                logic [16:0] a;
                case (k)
                    0: a = 17'h00000; 1: a = 17'h0FFFF; 2: a = 17'h10000;
                    3: a = 17'h17FFF; 4: a = 17'h18000; default: a = 17'h1FFFF;
                endcase
                mem_wr = 1; mem_addr = a; tick("R6");
            end
            cmd_end = 1; tick("R5");
            chk("R5 latch cleared after burst", {7'd0, status[1]}, 8'd0);
        end

        // Burst with no lock: every byte granted
        cmd_set("R5");
        cmd_sr("R5", 8'h00, 1'b1);
        cmd_set("R5");
        cs_fall = 1; tick("R5");
        for (int k = 0; k < 4; k++) begin
            mem_wr = 1; mem_addr = 17'h1FFFC + 17'(k);
            #1 chk("R5 burst byte granted", {7'd0, mem_wr_ok}, 8'd1);
            tick("R5");
        end
        cmd_end = 1; tick("R5");
        chk("R5 latch cleared", status, 8'h40);

        // Pin enable on, pin low: status locked, memory open
        cmd_set("R8");
        cmd_sr("R8", 8'h80, 1'b1);
        chk("R8 pen set", status, 8'hC0);
        wp_n = 0; cmd_set("R8");
        wp_n = 0; cs_fall = 1; tick("R8");
        #1 chk("R8 status locked by pin", {7'd0, sr_wr_ok}, 8'd0);
        sr_wr = 1; sr_data = 8'h0C; tick("R9");
        cmd_end = 1; tick("R9");
        chk("R9 denied write, latch cleared", status, 8'hC0);
        wp_n = 0; cmd_set("R7");
        cs_fall = 1; tick("R7");
        mem_wr = 1; mem_addr = 17'h1FFFF;
        #1 chk("R7 pin ignored for memory", {7'd0, mem_wr_ok}, 8'd1);
        tick("R7"); cmd_end = 1; tick("R7");

        // Pin falls after command start: still granted
        cmd_set("R8");
        wp_n = 1; cs_fall = 1; tick("R8");
        wp_n = 0; tick("R8");
        #1 chk("R8 mid-command pin low ignored", {7'd0, sr_wr_ok}, 8'd1);
        sr_wr = 1; sr_data = 8'h84; tick("R8");
        cmd_end = 1; tick("R8");
        chk("R8 write took effect", status, 8'hC4);

        // Pin rises after command start: still denied
        cmd_set("R8");
        wp_n = 0; cs_fall = 1; tick("R8");
        wp_n = 1; tick("R8");
        sr_wr = 1; sr_data = 8'h00; tick("R9");
        cmd_end = 1; tick("R9");
        chk("R9 status kept", status, 8'hC4);

        // Soft reset keeps protection bits
        cmd_set("R10");
        rst_n = 0; tick("R10"); rst_n = 1;
        #1 chk("R10 soft reset", status, 8'hC4);
        tick("R10");

        por_n = 0; tick("R2"); por_n = 1;
        #1 chk("R2 power reset clears all", status, 8'h40);
        tick("R2");
        summary();
    end
endmodule